// File: doc/BRIEF.md
# Two-Dimensional Strided Address Walker

This block turns a single region description into a stream of bus-beat addresses for one side (source or destination) of a memory mover. A region is a number of rows, each a fixed number of bytes long. Each row starts one stride beyond the start of the row before it. Inside a row the address steps by the bus width in bytes. Downstream logic splits the beats into bursts and drives the bus protocol; this block only decides which address comes next and where rows and the whole region end.

A request carries a base address, the row length in bytes minus one, the row count minus one, the row stride and a cyclic flag. It is taken with a valid/ready handshake while the walker is idle. Beats leave on a valid/ready stream that carries an end-of-row marker and an end-of-region marker. The walker exposes the address it is currently offering, and pulses `done` once for each completed pass. In cyclic mode it replays the region from its base with no new request until `abort` is raised. `abort` returns it to idle at once and throws away whatever part of a row is left. A build option drops the row dimension, and then every request walks exactly one row.

Top module: `rect_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, `beat_valid` is 0, `done` is 0 and `cur_addr` is 0.
- R2: A row of L bytes, with L = `req_xlen_m1`+1, is issued as L/BUS_BYTES beats. Beat i of a row sits at the row start plus i*BUS_BYTES.
- R3: A region has `req_ylen_m1`+1 rows, and row k starts at base + k*stride, with the address wrapping modulo 2^ADDR_W.
- R4: `beat_row_end` is 1 exactly on the last beat of every row. `beat_xfer_end` is 1 exactly on the last beat of the last row.
- R5: `done` is high for one cycle, the cycle after the beat flagged `beat_xfer_end` is accepted, and at no other time.
- R6: With `req_cyclic`=1, the beat offered right after the last beat of a pass is the base address again, and `done` pulses at the end of every pass.
- R7: While `beat_valid` is 1 and `beat_ready` is 0, the offered address and both markers hold steady into the next cycle.
- R8: `req_ready` is 1 only while idle. A request presented while a region is running is ignored and does not disturb the beats being issued.
- R9: `abort` makes `beat_valid` 0 and leaves `done` at 0 in the next cycle, even when it coincides with acceptance of the final beat. The next request starts cleanly at its own base.
- R10: Only aligned values are used. The low log2(BUS_BYTES) bits of base, stride and row length minus one are ignored, so with BUS_BYTES=8 a base of 0x1005 walks from 0x1000.
- R11: Row length bits at and above XLEN_W, and row count bits at and above YLEN_W, are ignored. With the defaults (12 and 8), an X value of 0x0001F00F acts as 0x00F and a Y value of 0x301 acts as 0x01.
- R12: When built with HAS_2D=0, every request issues a single row, whatever `req_ylen_m1` holds.
- R13: While `beat_valid` is 1, `cur_addr` equals `beat_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Region request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_base | input | ADDR_W | Region base address |
| req_xlen_m1 | input | ADDR_W | Row length in bytes minus one |
| req_ylen_m1 | input | ADDR_W | Row count minus one |
| req_stride | input | ADDR_W | Distance between row starts in bytes |
| req_cyclic | input | 1 | Replay the region until aborted |
| abort | input | 1 | Return to idle, dropping the rest of the region |
| beat_valid | output | 1 | A beat address is offered |
| beat_ready | input | 1 | Downstream takes the offered beat |
| beat_addr | output | ADDR_W | Address of the offered beat |
| beat_row_end | output | 1 | Offered beat ends a row |
| beat_xfer_end | output | 1 | Offered beat ends the region |
| cur_addr | output | ADDR_W | Live current address |
| done | output | 1 | One-cycle pulse per completed pass |

## Verification
Two pairs of functions can fall in the same cycle. In cyclic mode, the `done` pulse of one pass comes in the same cycle as the first beat of the replay. The bench holds the sink ready until the expected queue drains, then expects both the pulse and the base address in that next cycle. The other pair is an abort that lands in exactly the cycle the final beat is accepted. The driver raises `abort` when one expected beat is left, and the monitor then requires no `done` pulse and an idle stream.

// File: rtl/rect_walker_pkg.sv
package rect_walker_pkg;

    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_RUN  = 1'b1
    } walk_state_e;

    typedef struct packed {
        logic row_last;
        logic xfer_last;
    } walk_pos_t;

    // Clears the low sh bits of a value (alignment to the bus width).
    function automatic logic [63:0] clear_low(input logic [63:0] v, input int unsigned sh);
        logic [63:0] m;
        m = ~64'd0 << sh;
        return v & m;
    endfunction

endpackage

// File: rtl/walk_cfg_reg.sv
module walk_cfg_reg #(
    parameter int ADDR_W = 32,
    parameter int XCNT_W = 9,
    parameter int YCNT_W = 8,
    parameter bit HAS_2D = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] in_base,
    input  logic [ADDR_W-1:0] in_stride,
    input  logic [XCNT_W-1:0] in_xbeats_m1,
    input  logic [YCNT_W-1:0] in_yrows_m1,
    input  logic              in_cyclic,
    output logic [ADDR_W-1:0] base_q,
    output logic [ADDR_W-1:0] stride_q,
    output logic [XCNT_W-1:0] xbeats_m1_q,
    output logic [YCNT_W-1:0] yrows_m1_q,
    output logic              cyclic_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q      <= '0;
            stride_q    <= '0;
            xbeats_m1_q <= '0;
            cyclic_q    <= 1'b0;
        end else if (load) begin
            base_q      <= in_base;
            stride_q    <= in_stride;
            xbeats_m1_q <= in_xbeats_m1;
            cyclic_q    <= in_cyclic;
        end
    end

    generate
        if (HAS_2D) begin : g_rows
            always_ff @(posedge clk) begin
                if (rst)       yrows_m1_q <= '0;
                else if (load) yrows_m1_q <= in_yrows_m1;
            end
        end else begin : g_flat
            assign yrows_m1_q = '0;
        end
    endgenerate

endmodule

// File: rtl/walk_axis_cnt.sv
module walk_axis_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt,
    output logic         at_limit
);

    always_ff @(posedge clk) begin
        if (rst)      cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end

    assign at_limit = (cnt == limit);

endmodule

// File: rtl/walk_row_addr.sv
module walk_row_addr #(
    parameter int ADDR_W = 32,
    parameter int STEP   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              next_beat,
    input  logic              next_row,
    input  logic [ADDR_W-1:0] stride,
    output logic [ADDR_W-1:0] beat_q
);

    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    logic [ADDR_W-1:0] row_q;
    logic [ADDR_W-1:0] row_next;

    assign row_next = row_q + stride;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q  <= '0;
            beat_q <= '0;
        end else if (load) begin
            row_q  <= load_val;
            beat_q <= load_val;
        end else if (next_row) begin
            row_q  <= row_next;
            beat_q <= row_next;
        end else if (next_beat) begin
            beat_q <= beat_q + STEP_V;
        end
    end

endmodule

// File: rtl/rect_walker.sv
module rect_walker
    import rect_walker_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int XLEN_W    = 12,
    parameter int YLEN_W    = 8,
    parameter int BUS_BYTES = 8,
    parameter bit HAS_2D    = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [ADDR_W-1:0] req_xlen_m1,
    input  logic [ADDR_W-1:0] req_ylen_m1,
    input  logic [ADDR_W-1:0] req_stride,
    input  logic              req_cyclic,
    input  logic              abort,
    output logic              beat_valid,
    input  logic              beat_ready,
    output logic [ADDR_W-1:0] beat_addr,
    output logic              beat_row_end,
    output logic              beat_xfer_end,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              done
);

    localparam int SH     = $clog2(BUS_BYTES);
    localparam int XCNT_W = XLEN_W - SH;
    localparam int YCNT_W = YLEN_W;

    walk_state_e state_q, state_d;
    walk_pos_t   pos;

    logic [ADDR_W-1:0] norm_base, norm_stride, load_val;
    logic [XCNT_W-1:0] norm_xbeats_m1;
    logic [YCNT_W-1:0] norm_yrows_m1;

    logic [ADDR_W-1:0] base_q, stride_q, beat_q;
    logic [XCNT_W-1:0] xbeats_m1_q, xcnt;
    logic [YCNT_W-1:0] yrows_m1_q, ycnt;
    logic              cyclic_q, x_at_lim, y_at_lim;

    logic running, accept, fire, pass_end, restart, load;
    logic next_row, next_beat, done_q;

    // Request normalisation: alignment and implemented widths.
    assign norm_base      = ADDR_W'(clear_low(64'(req_base), SH));
    assign norm_stride    = ADDR_W'(clear_low(64'(req_stride), SH));
    assign norm_xbeats_m1 = XCNT_W'(req_xlen_m1 >> SH);
    assign norm_yrows_m1  = YCNT_W'(req_ylen_m1);

    assign running   = (state_q == WALK_RUN);
    assign accept    = req_valid && !running && !abort;
    assign fire      = running && beat_ready && !abort;

    assign pos.row_last  = x_at_lim;
    assign pos.xfer_last = x_at_lim && y_at_lim;

    assign pass_end  = fire && pos.xfer_last;
    assign restart   = pass_end && cyclic_q;
    assign load      = accept || restart;
    assign next_row  = fire && pos.row_last && !pos.xfer_last;
    assign next_beat = fire && !pos.row_last;
    assign load_val  = accept ? norm_base : base_q;

    walk_cfg_reg #(
        .ADDR_W(ADDR_W), .XCNT_W(XCNT_W), .YCNT_W(YCNT_W), .HAS_2D(HAS_2D)
    ) u_cfg (
        .clk(clk), .rst(rst), .load(accept),
        .in_base(norm_base), .in_stride(norm_stride),
        .in_xbeats_m1(norm_xbeats_m1), .in_yrows_m1(norm_yrows_m1),
        .in_cyclic(req_cyclic),
        .base_q(base_q), .stride_q(stride_q),
        .xbeats_m1_q(xbeats_m1_q), .yrows_m1_q(yrows_m1_q),
        .cyclic_q(cyclic_q)
    );

    walk_axis_cnt #(.W(XCNT_W)) u_xcnt (
        .clk(clk), .rst(rst), .clr(load || next_row), .inc(next_beat),
        .limit(xbeats_m1_q), .cnt(xcnt), .at_limit(x_at_lim)
    );

    walk_axis_cnt #(.W(YCNT_W)) u_ycnt (
        .clk(clk), .rst(rst), .clr(load), .inc(next_row),
        .limit(yrows_m1_q), .cnt(ycnt), .at_limit(y_at_lim)
    );

    walk_row_addr #(.ADDR_W(ADDR_W), .STEP(BUS_BYTES)) u_addr (
        .clk(clk), .rst(rst), .load(load), .load_val(load_val),
        .next_beat(next_beat), .next_row(next_row),
        .stride(stride_q), .beat_q(beat_q)
    );

    always_comb begin
        state_d = state_q;
        if (abort)                      state_d = WALK_IDLE;
        else if (accept)                state_d = WALK_RUN;
        else if (pass_end && !cyclic_q) state_d = WALK_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WALK_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= pass_end;
        end
    end

    assign req_ready     = !running;
    assign beat_valid    = running;
    assign beat_addr     = beat_q;
    assign beat_row_end  = running && pos.row_last;
    assign beat_xfer_end = running && pos.xfer_last;
    assign cur_addr      = beat_q;
    assign done          = done_q;

endmodule

// File: rtl/rect_walker_chk.sv
module rect_walker_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              abort,
    input logic              beat_valid,
    input logic              beat_ready,
    input logic [ADDR_W-1:0] beat_addr,
    input logic              beat_row_end,
    input logic              beat_xfer_end,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              done
);

    // R7
    beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !beat_ready && !abort) |=>
        (beat_valid && $stable(beat_addr) && $stable(beat_row_end) && $stable(beat_xfer_end)));

    // R5
    done_src_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(beat_valid && beat_ready && beat_xfer_end && !abort));

    // R8
    idle_excl_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !beat_valid);

    // R9
    abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!beat_valid && !done));

    // R4
    end_nest_chk: assert property (@(posedge clk) disable iff (rst)
        beat_xfer_end |-> beat_row_end);

    // R13
    cur_match_chk: assert property (@(posedge clk) disable iff (rst)
        beat_valid |-> (cur_addr == beat_addr));

endmodule

bind rect_walker rect_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready), .abort(abort),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_addr(beat_addr),
    .beat_row_end(beat_row_end), .beat_xfer_end(beat_xfer_end),
    .cur_addr(cur_addr), .done(done)
);

// File: tb/rect_walker_test.sv
`timescale 1ns/1ps
module rect_walker_test;

    localparam int AW = 32;
    localparam int XW = 12;
    localparam int YW = 8;
    localparam int BB = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, f_req_valid = 1'b0;
    logic          req_ready, f_req_ready;
    logic [AW-1:0] req_base = '0, req_xlen_m1 = '0, req_ylen_m1 = '0, req_stride = '0;
    logic          req_cyclic = 1'b0;
    logic          abort = 1'b0, f_abort = 1'b0;
    logic          beat_valid, f_beat_valid;
    logic          beat_ready = 1'b0, f_beat_ready = 1'b1;
    logic [AW-1:0] beat_addr, cur_addr, f_beat_addr, f_cur_addr;
    logic          beat_row_end, beat_xfer_end, done;
    logic          f_beat_row_end, f_beat_xfer_end, f_done;

    always #4 clk = ~clk;

    rect_walker #(.ADDR_W(AW), .XLEN_W(XW), .YLEN_W(YW), .BUS_BYTES(BB), .HAS_2D(1'b1)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_base(req_base), .req_xlen_m1(req_xlen_m1), .req_ylen_m1(req_ylen_m1),
        .req_stride(req_stride), .req_cyclic(req_cyclic), .abort(abort),
        .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_addr(beat_addr),
        .beat_row_end(beat_row_end), .beat_xfer_end(beat_xfer_end),
        .cur_addr(cur_addr), .done(done)
    );

    rect_walker #(.ADDR_W(AW), .XLEN_W(XW), .YLEN_W(YW), .BUS_BYTES(BB), .HAS_2D(1'b0)) uut_flat (
        .clk(clk), .rst(rst), .req_valid(f_req_valid), .req_ready(f_req_ready),
        .req_base(req_base), .req_xlen_m1(req_xlen_m1), .req_ylen_m1(req_ylen_m1),
        .req_stride(req_stride), .req_cyclic(req_cyclic), .abort(f_abort),
        .beat_valid(f_beat_valid), .beat_ready(f_beat_ready), .beat_addr(f_beat_addr),
        .beat_row_end(f_beat_row_end), .beat_xfer_end(f_beat_xfer_end),
        .cur_addr(f_cur_addr), .done(f_done)
    );

    int checks = 0;
    int errors = 0;
    int done_seen = 0;
    int cyc = 0;
    bit stall_mode = 1'b0;
    bit exp_done_pend = 1'b0;
    bit prev_hold = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    logic [AW+1:0] exp_q[$];

    int            f_n = 0;
    int            f_dn = 0;
    logic [AW-1:0] f_addr[4];
    logic          f_last[4];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected beats from the requirements (R2, R3, R4, R10, R11).
    task automatic push_region(input logic [AW-1:0] base, input logic [AW-1:0] xm1,
                               input logic [AW-1:0] ym1, input logic [AW-1:0] stride,
                               input int passes);
        logic [AW-1:0] b, s, a;
        int nb, nr;
        b  = base & ~AW'(BB - 1);
        s  = stride & ~AW'(BB - 1);
        nb = int'((xm1 & AW'((1 << XW) - 1)) >> 3) + 1;
        nr = int'(ym1 & AW'((1 << YW) - 1)) + 1;
        for (int p = 0; p < passes; p++)
            for (int r = 0; r < nr; r++)
                for (int i = 0; i < nb; i++) begin
                    a = b + AW'(r) * s + AW'(i * BB);
                    exp_q.push_back({a, (i == nb - 1), (i == nb - 1) && (r == nr - 1)});
                end
    endtask

    task automatic send(input logic [AW-1:0] base, input logic [AW-1:0] xm1,
                        input logic [AW-1:0] ym1, input logic [AW-1:0] stride, input bit cyc_f);
        @(posedge clk); #1;
        req_base = base; req_xlen_m1 = xm1; req_ylen_m1 = ym1;
        req_stride = stride; req_cyclic = cyc_f; req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) begin
            @(posedge clk); #1;
        end
    endtask

    // Sink: ready only while the scoreboard expects beats.
    initial forever begin
        @(posedge clk); #1;
        cyc++;
        beat_ready = (exp_q.size() > 0) && (!stall_mode || (cyc % 3 != 1));
    end

    // Monitor and scoreboard.
    always @(negedge clk) begin
        if (rst) begin
            exp_done_pend = 1'b0;
            prev_hold = 1'b0;
        end else begin
            if (done || exp_done_pend)
                chk(done == exp_done_pend, "R5 done pulse timing", done, exp_done_pend);
            if (done) done_seen++;
            exp_done_pend = 1'b0;
            if (beat_valid)
                chk(cur_addr == beat_addr, "R13 live address", cur_addr, beat_addr);
            if (prev_hold)
                chk(beat_valid && beat_addr == prev_addr, "R7 stalled beat held", beat_addr, prev_addr);
            prev_hold = beat_valid && !beat_ready && !abort;
            prev_addr = beat_addr;
            if (beat_valid && beat_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected beat", beat_addr, 0);
                end else begin
                    logic [AW+1:0] item;
                    item = exp_q.pop_front();
                    chk({beat_addr, beat_row_end, beat_xfer_end} == item,
                        "R2 R3 R4 beat address and markers",
                        {beat_addr, beat_row_end, beat_xfer_end}, item);
                    if (beat_xfer_end && !abort) exp_done_pend = 1'b1;
                end
            end
        end
    end

    // Logger for the one-row build.
    always @(negedge clk) begin
        if (!rst) begin
            if (f_beat_valid) begin
                if (f_n < 4) begin
                    f_addr[f_n] = f_beat_addr;
                    f_last[f_n] = f_beat_xfer_end;
                end
                f_n++;
            end
            if (f_done) f_dn++;
        end
    end

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int d0;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 req_ready after reset", req_ready, 1);
        chk(beat_valid == 1'b0, "R1 beat_valid after reset", beat_valid, 0);
        chk(done == 1'b0, "R1 done after reset", done, 0);
        chk(cur_addr == '0, "R1 cur_addr after reset", cur_addr, 0);

        // R2 R3 R4: 4 beats x 3 rows, stride 0x80
        d0 = done_seen;
        push_region(32'h1000, 32'd31, 32'd2, 32'h80, 1);
        send(32'h1000, 32'd31, 32'd2, 32'h80, 1'b0);
        drain();
        repeat (3) @(negedge clk);
        chk(done_seen == d0 + 1, "R5 one done per region", done_seen, d0 + 1);
        chk(req_ready == 1'b1, "R8 idle after region", req_ready, 1);

        // R7 stalls, R8 request during run
        stall_mode = 1'b1;
        push_region(32'h4000, 32'd23, 32'd3, 32'h40, 1);
        send(32'h4000, 32'd23, 32'd3, 32'h40, 1'b0);
        repeat (4) @(posedge clk);
        #1;
        req_base = 32'hFFFF_0000; req_valid = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b0 && beat_valid == 1'b1, "R8 busy refuses request", req_ready, 0);
        @(posedge clk); #1 req_valid = 1'b0;
        drain();
        stall_mode = 1'b0;
        repeat (3) @(negedge clk);

        // R10 alignment
        push_region(32'h1005, 32'h1A, 32'd1, 32'h10F, 1);
        send(32'h1005, 32'h1A, 32'd1, 32'h10F, 1'b0);
        drain();
        repeat (3) @(negedge clk);

        // R11 unimplemented upper bits
        push_region(32'h2000, 32'h0001_F00F, 32'h0000_0301, 32'h100, 1);
        send(32'h2000, 32'h0001_F00F, 32'h0000_0301, 32'h100, 1'b0);
        drain();
        repeat (3) @(negedge clk);

        // R6 cyclic replay, then abort (R9)
        d0 = done_seen;
        push_region(32'h8000, 32'd15, 32'd1, 32'h20, 2);
        send(32'h8000, 32'd15, 32'd1, 32'h20, 1'b1);
        drain();
        @(negedge clk);
        chk(beat_valid == 1'b1 && beat_addr == 32'h8000, "R6 replay restarts at base", beat_addr, 32'h8000);
        @(posedge clk); #1 abort = 1'b1;
        @(posedge clk); #1 abort = 1'b0;
        @(negedge clk);
        chk(beat_valid == 1'b0 && req_ready == 1'b1, "R9 idle after abort", beat_valid, 0);
        chk(done_seen == d0 + 2, "R6 done each pass", done_seen, d0 + 2);

        // R9 abort on final beat suppresses done
        d0 = done_seen;
        push_region(32'h9000, 32'd7, 32'd1, 32'h10, 1);
        send(32'h9000, 32'd7, 32'd1, 32'h10, 1'b0);
        while (!(exp_q.size() == 1 && beat_valid)) begin
            @(posedge clk); #1;
        end
        abort = 1'b1;
        @(posedge clk); #1 abort = 1'b0;
        repeat (2) @(negedge clk);
        chk(done_seen == d0, "R9 no done on aborted final beat", done_seen, d0);
        chk(beat_valid == 1'b0, "R9 stream idle", beat_valid, 0);

        // R9 mid-row abort, then a clean single-beat region
        push_region(32'hA000, 32'd31, 32'd3, 32'h40, 1);
        send(32'hA000, 32'd31, 32'd3, 32'h40, 1'b0);
        while (exp_q.size() > 11) begin
            @(posedge clk); #1;
        end
        abort = 1'b1;
        @(posedge clk); #1 abort = 1'b0;
        exp_q.delete();
        repeat (2) @(negedge clk);
        chk(beat_valid == 1'b0, "R9 partial row dropped", beat_valid, 0);
        d0 = done_seen;
        push_region(32'hB000, 32'd7, 32'd0, 32'h0, 1);
        send(32'hB000, 32'd7, 32'd0, 32'h0, 1'b0);
        drain();
        repeat (3) @(negedge clk);
        chk(done_seen == d0 + 1, "R9 fresh region after abort", done_seen, d0 + 1);

        // R12 one-row build ignores the row count
        f_n = 0; f_dn = 0;
        @(posedge clk); #1;
        req_base = 32'h3000; req_xlen_m1 = 32'd15; req_ylen_m1 = 32'd5;
        req_stride = 32'h100; req_cyclic = 1'b0; f_req_valid = 1'b1;
        @(posedge clk); #1 f_req_valid = 1'b0;
        repeat (8) @(negedge clk);
        chk(f_n == 2, "R12 single row beat count", f_n, 2);
        chk(f_addr[0] == 32'h3000 && f_addr[1] == 32'h3008, "R12 single row addresses", f_addr[1], 32'h3008);
        chk(f_last[0] == 1'b0 && f_last[1] == 1'b1, "R12 end marker on second beat", f_last[1], 1);
        chk(f_dn == 1, "R12 one done", f_dn, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule